// File: doc/BRIEF.md
# Delayed Branch Resolver

This unit decides the outcome of a PC-relative conditional branch in a pipeline that has one branch delay slot. In the cycle a branch is presented, the unit receives the branch address, a 16-bit word offset, a selector for one of eight floating-point condition bits, the current condition vector, and four controls. One control sets the sense of the test (branch on true or on false). One control marks the "likely" form. One control requests a link. The last control forces the branch to be taken, which covers the idiom that compares register 0 with itself.

One clock later, while the delay-slot instruction is in the cycle behind the branch, the unit gives its result. The result is the address to fetch after the delay slot, a kill signal for the delay-slot instruction, and a link write of the return address to register 31. If a second branch or jump arrives while a delay slot is still open, the unit does not resolve it and raises an error flag.

Top module: `dslot_branch_unit`

## Requirements
- R1: During reset and after reset, before any branch is presented, `res_valid`, `slot_kill`, `link_we` and `seq_err` are all 0.
- R2: The taken target is (br_pc + 4) + the offset, where the offset is `br_offset` shifted left by two and sign-extended from 18 bits. The addition is modulo 2^32.
- R3: A branch presented when no delay slot is open gives `res_valid` = 1 in the next cycle only, for exactly one cycle.
- R4: A branch is taken when `cc_vec[cc_sel]` equals `br_on_true`; in that case `next_pc` is the target.
- R5: When a branch is not taken, `next_pc` is br_pc + 8.
- R6: `slot_kill` is 1 exactly when `br_likely` = 1 and the branch is not taken. A taken likely branch keeps its delay slot.
- R7: When `br_link` = 1, `link_we` is 1 in the result cycle and `link_val` is br_pc + 8, whether or not the branch is taken.
- R8: When `br_always` = 1, the branch is taken whatever the condition vector holds, and it never kills its slot.
- R9: A branch presented while a result cycle is open is not resolved. In the next cycle `seq_err` = 1 and `res_valid` = 0.
- R10: Only the bit chosen by `cc_sel` decides the outcome. The other seven bits have no effect on `next_pc` or `slot_kill`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch is presented this cycle |
| br_pc | input | 32 | Address of the branch instruction |
| br_offset | input | 16 | Signed word offset |
| br_on_true | input | 1 | 1: branch when the selected bit is 1; 0: branch when it is 0 |
| br_likely | input | 1 | Kill the delay slot if the branch is not taken |
| br_link | input | 1 | Write the return address to register 31 |
| br_always | input | 1 | Unconditional form, always taken |
| cc_sel | input | 3 | Index of the condition bit to test |
| cc_vec | input | 8 | Current floating-point condition bits |
| res_valid | output | 1 | Result cycle (the delay slot is in flight) |
| next_pc | output | 32 | Address to fetch after the delay slot |
| slot_kill | output | 1 | Annul the delay-slot instruction |
| link_we | output | 1 | Write enable for register 31 |
| link_val | output | 32 | Return address, branch + 8 |
| seq_err | output | 1 | A branch arrived inside an open delay slot |

## Verification
A corrupted captured target or condition bit shows up as a wrong `next_pc` or `slot_kill` in the result cycle itself, one clock after the branch. A stuck pending flag shows up as `res_valid` lasting two cycles or never rising, or as a spurious `seq_err` on the next branch. Each random branch is followed by an idle cycle, so every one of these faults is seen within two clocks of its cause.

// File: rtl/dsb_pkg.sv
package dsb_pkg;
  localparam int unsigned INSN_BYTES = 4;

  typedef struct packed {
    logic taken;
    logic kill;
    logic link;
  } dsb_ctl_t;
endpackage

// File: rtl/dsb_target.sv
module dsb_target #(
  parameter int unsigned AW   = 32,
  parameter int unsigned OFFW = 16
) (
  input  logic [AW-1:0]   pc,
  input  logic [OFFW-1:0] off,
  output logic [AW-1:0]   tgt,
  output logic [AW-1:0]   seq
);
  import dsb_pkg::*;
  localparam int unsigned SHW = OFFW + 2;

  logic [AW-1:0] off_ext;
  logic [AW-1:0] slot_pc;

  always_comb begin
    off_ext = {{(AW-SHW){off[OFFW-1]}}, off, 2'b00};
    slot_pc = pc + AW'(INSN_BYTES);
    tgt     = slot_pc + off_ext;
    seq     = pc + AW'(2 * INSN_BYTES);
  end
endmodule

// File: rtl/dsb_cond.sv
module dsb_cond #(
  parameter int unsigned CCN = 8,
  localparam int unsigned CCW = (CCN > 1) ? $clog2(CCN) : 1
) (
  input  logic [CCN-1:0]     cc_vec,
  input  logic [CCW-1:0]     cc_sel,
  input  logic               on_true,
  input  logic               always_tk,
  input  logic               likely,
  input  logic               link,
  output dsb_pkg::dsb_ctl_t  ctl
);
  logic [CCN-1:0] sel_hot;
  logic           cc_bit;

  genvar gi;
  generate
    for (gi = 0; gi < CCN; gi++) begin : g_sel
      assign sel_hot[gi] = (cc_sel == CCW'(gi)) & cc_vec[gi];
    end
  endgenerate

  always_comb begin
    cc_bit    = |sel_hot;
    ctl.taken = always_tk | (cc_bit == on_true);
    ctl.kill  = likely & ~ctl.taken;
    ctl.link  = link;
  end
endmodule

// File: rtl/dslot_branch_unit.sv
module dslot_branch_unit #(
  parameter int unsigned AW   = 32,
  parameter int unsigned OFFW = 16,
  parameter int unsigned CCN  = 8,
  localparam int unsigned CCW = (CCN > 1) ? $clog2(CCN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            br_valid,
  input  logic [AW-1:0]   br_pc,
  input  logic [OFFW-1:0] br_offset,
  input  logic            br_on_true,
  input  logic            br_likely,
  input  logic            br_link,
  input  logic            br_always,
  input  logic [CCW-1:0]  cc_sel,
  input  logic [CCN-1:0]  cc_vec,
  output logic            res_valid,
  output logic [AW-1:0]   next_pc,
  output logic            slot_kill,
  output logic            link_we,
  output logic [AW-1:0]   link_val,
  output logic            seq_err
);
  import dsb_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [AW-1:0] tgt_c, seq_c;
  dsb_ctl_t      ctl_c;

  dsb_target #(.AW(AW), .OFFW(OFFW)) u_tgt (
    .pc  (br_pc),
    .off (br_offset),
    .tgt (tgt_c),
    .seq (seq_c)
  );

  dsb_cond #(.CCN(CCN)) u_cond (
    .cc_vec    (cc_vec),
    .cc_sel    (cc_sel),
    .on_true   (br_on_true),
    .always_tk (br_always),
    .likely    (br_likely),
    .link      (br_link),
    .ctl       (ctl_c)
  );

  // next-state
  logic          pend_q, pend_d;
  logic          err_q, err_d;
  logic          cap_en;
  dsb_ctl_t      ctl_q;
  logic [AW-1:0] tgt_q, seq_q;

  always_comb begin
    pend_d = br_valid & ~pend_q;
    err_d  = br_valid & pend_q;
    cap_en = pend_d;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctl_q <= '0;
      tgt_q <= '0;
      seq_q <= '0;
    end else if (cap_en) begin
      ctl_q <= ctl_c;
      tgt_q <= tgt_c;
      seq_q <= seq_c;
    end
  end

  always_comb begin
    res_valid = pend_q;
    next_pc   = ctl_q.taken ? tgt_q : seq_q;
    slot_kill = pend_q & ctl_q.kill;
    link_we   = pend_q & ctl_q.link;
    link_val  = seq_q;
    seq_err   = err_q;
  end

  AST_RESOLVE_NEXT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (br_valid && !res_valid) |=> res_valid); // R3
  AST_SLOT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    res_valid |=> !res_valid); // R3
  AST_NEST_FLAGGED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (br_valid && res_valid) |=> (seq_err && !res_valid)); // R9
  AST_KILL_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_int_n)
    slot_kill |-> (next_pc == link_val)); // R6
  AST_ALWAYS_NO_KILL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (br_valid && !res_valid && br_always) |=> !slot_kill); // R8
endmodule

// File: tb/tb_dslot_branch_unit.sv
module tb_dslot_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        br_valid;
  logic [31:0] br_pc;
  logic [15:0] br_offset;
  logic        br_on_true, br_likely, br_link, br_always;
  logic [2:0]  cc_sel;
  logic [7:0]  cc_vec;
  logic        res_valid, slot_kill, link_we, seq_err;
  logic [31:0] next_pc, link_val;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dslot_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pc(br_pc),
    .br_offset(br_offset), .br_on_true(br_on_true), .br_likely(br_likely),
    .br_link(br_link), .br_always(br_always), .cc_sel(cc_sel), .cc_vec(cc_vec),
    .res_valid(res_valid), .next_pc(next_pc), .slot_kill(slot_kill),
    .link_we(link_we), .link_val(link_val), .seq_err(seq_err)
  );

  function automatic logic [31:0] exp_tgt(input logic [31:0] pc, input logic [15:0] off);
    return pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
  endfunction

  function automatic logic exp_taken(input logic alw, input logic t, input logic [7:0] v,
                                     input logic [2:0] s);
    return alw | (v[s] == t);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] pc, input logic [15:0] off, input logic t,
                       input logic lk, input logic ln, input logic alw,
                       input logic [2:0] s, input logic [7:0] v);
    br_valid = 1'b1; br_pc = pc; br_offset = off; br_on_true = t;
    br_likely = lk; br_link = ln; br_always = alw; cc_sel = s; cc_vec = v;
  endtask

  task automatic check_result(input logic [31:0] pc, input logic [15:0] off, input logic t,
                              input logic lk, input logic ln, input logic alw,
                              input logic [2:0] s, input logic [7:0] v);
    logic tk;
    logic [31:0] enp;
    tk  = exp_taken(alw, t, v, s);
    enp = tk ? exp_tgt(pc, off) : pc + 32'd8;
    chk(res_valid === 1'b1, "R3 res_valid", {31'd0, res_valid}, 32'd1);
    chk(next_pc === enp, tk ? "R2/R4 next_pc taken" : "R5 next_pc fallthrough", next_pc, enp);
    chk(slot_kill === (lk & ~tk), "R6 slot_kill", {31'd0, slot_kill}, {31'd0, lk & ~tk});
    chk(link_we === ln, "R7 link_we", {31'd0, link_we}, {31'd0, ln});
    if (ln) chk(link_val === pc + 32'd8, "R7 link_val", link_val, pc + 32'd8);
    chk(seq_err === 1'b0, "R9 seq_err idle", {31'd0, seq_err}, 32'd0);
  endtask

  task automatic one_branch(input logic [31:0] pc, input logic [15:0] off, input logic t,
                            input logic lk, input logic ln, input logic alw,
                            input logic [2:0] s, input logic [7:0] v);
    drive(pc, off, t, lk, ln, alw, s, v);
    @(negedge clk);
    br_valid = 1'b0;
    br_always = 1'b0;
    check_result(pc, off, t, lk, ln, alw, s, v);
    @(negedge clk);
    chk(res_valid === 1'b0, "R3 single cycle", {31'd0, res_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(32'h0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 8'h0);
    br_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk({res_valid, slot_kill, link_we, seq_err} === 4'b0, "R1 in reset",
        {28'd0, res_valid, slot_kill, link_we, seq_err}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({res_valid, slot_kill, link_we, seq_err} === 4'b0, "R1 after reset",
        {28'd0, res_valid, slot_kill, link_we, seq_err}, 32'd0);

    // directed
    one_branch(32'h0000_1000, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h01); // R2 zero offset
    one_branch(32'h0000_1000, 16'h7FFF, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 8'h08); // R2 max forward
    one_branch(32'h0004_0000, 16'h8000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd7, 8'h7F); // R2 max backward
    one_branch(32'hFFFF_FFF0, 16'h0010, 1'b1, 1'b0, 1'b0, 1'b0, 3'd1, 8'h02); // R2 wrap
    one_branch(32'h0000_2000, 16'h0040, 1'b1, 1'b1, 1'b0, 1'b0, 3'd5, 8'hDF); // R6 likely not taken
    one_branch(32'h0000_2000, 16'h0040, 1'b0, 1'b1, 1'b0, 1'b0, 3'd5, 8'hDF); // R6 likely taken
    one_branch(32'h0000_3000, 16'hFFFE, 1'b1, 1'b1, 1'b1, 1'b1, 3'd2, 8'h00); // R8 always, R7
    one_branch(32'h0000_3000, 16'h0100, 1'b1, 1'b0, 1'b1, 1'b0, 3'd4, 8'h00); // R7 link not taken
    one_branch(32'h0000_4000, 16'h0020, 1'b1, 1'b1, 1'b0, 1'b0, 3'd6, 8'hBF); // R10 others set
    one_branch(32'h0000_4000, 16'h0020, 1'b0, 1'b1, 1'b0, 1'b0, 3'd6, 8'h40); // R10 others clear

    // R9: second branch inside the open slot
    drive(32'h0000_5000, 16'h0008, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h01);
    @(negedge clk);
    check_result(32'h0000_5000, 16'h0008, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 8'h01);
    drive(32'h0000_5004, 16'h0100, 1'b1, 1'b1, 1'b1, 1'b0, 3'd0, 8'h00);
    @(negedge clk);
    br_valid = 1'b0;
    chk(seq_err === 1'b1, "R9 seq_err raised", {31'd0, seq_err}, 32'd1);
    chk(res_valid === 1'b0, "R9 nested not resolved", {31'd0, res_valid}, 32'd0);
    chk(link_we === 1'b0, "R9 nested no link", {31'd0, link_we}, 32'd0);
    @(negedge clk);
    chk({res_valid, seq_err} === 2'b00, "R9 clears", {30'd0, res_valid, seq_err}, 32'd0);

    // random
    void'($urandom(32'd12345));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rpc;
      logic [15:0] roff;
      logic [7:0]  rv;
      logic [5:0]  rc;
      rpc  = {$urandom(), 2'b00} ;
      roff = 16'($urandom());
      rv   = 8'($urandom());
      rc   = 6'($urandom());
      one_branch(rpc, roff, rc[0], rc[1], rc[2], (rc[5:3] == 3'd0),
                 3'($urandom()), rv);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule